// File: doc/BRIEF.md
# External interrupt line conditioner

This block sits between three external interrupt pins and a parent interrupt controller that only understands active-high level or rising-edge requests. Each pin is resynchronised on a sample-rate enable chosen per line, and then watched for a high level, a low level, a rising edge or a falling edge. Edge events are held in a sticky pending flag until software clears it. Low and falling inputs come out as active-high requests, so the parent needs no knowledge of the pin's polarity.

Each line is programmed through an 8-bit control byte reached over a simple single-cycle register port with byte enables. In separate mode each line has its own word address. In shared mode all three bytes are packed into the word at address 0, with line 0 in the highest used byte. The request of line n drives bit 13+n of the parent request vector.

Top module: `ext_irq_cond`

## Requirements
- R1: After reset every control byte reads 0 (high-level trigger, masked, slow sample rate, nothing pending) and every parent request bit is 0.
- R2: Control byte layout: bit 0 pending, bit 4 sample select, bit 5 enable, bits 7:6 trigger type; bits 3:1 read as 0 whatever was written.
- R3: Trigger encoding 00 = high level, 01 = low level, 10 = rising edge, 11 = falling edge. In level modes the request follows the synchronised pin, inverted for low level.
- R4: In edge modes a detected edge sets the pending flag, which stays set until a write with bit 0 = 1 to that line's byte.
- R5: In level modes the pending bit reads the current active state, and writing 1 to bit 0 has no effect.
- R6: With enable at 0 the line's request is 0 while its pending flag still latches. Setting enable releases a latched request.
- R7: Sample select 0 shifts the two-flop synchroniser on slow_tick_i, 1 on fast_tick_i. A pin change reaches the request after two selected ticks.
- R8: Line n drives parent_req_o bit 13+n, and all other parent bits stay 0.
- R9: With shared_mode_i = 1 the byte of line n sits at bits (2-n)*8+7:(2-n)*8 of address 0, a write changes only lines whose byte enable (be bit 2-n) is set, and other addresses read 0.
- R10: A write that changes a line's trigger type clears its latched edge pending flag.
- R11: With shared_mode_i = 0 line n is at address n, bits 7:0, written when be bit 0 is set. Address 3 reads 0 and writes to it change nothing.
- R12: An edge detected in the same cycle as a clearing write leaves the pending flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 3 | External interrupt pins, asynchronous |
| slow_tick_i | input | 1 | Slow sample-rate enable |
| fast_tick_i | input | 1 | Fast sample-rate enable |
| shared_mode_i | input | 1 | 1 packs all control bytes into address 0 |
| reg_addr_i | input | 2 | Register word address |
| reg_we_i | input | 1 | Register write strobe |
| reg_be_i | input | 4 | Byte enables of the write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| parent_req_o | output | 16 | Active-high requests to the parent controller |

## Verification
The bench builds the block with its defaults: three lines, a two-stage synchroniser, a 16-bit parent vector and a base index of 13. All three lines therefore land in the top parent bits, and the unused low bits can be watched for stray requests. The fast enable is held at 1 and the slow one pulses every eighth cycle, so the exact two-tick latency and the much slower slow-rate path both show up within a few cycles. The same build runs both the separate and the packed register layouts, with a reset between them.

// File: rtl/eic_pkg.sv
package eic_pkg;
  typedef enum logic [1:0] {
    TRIG_HIGH = 2'b00,
    TRIG_LOW  = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned BIT_PEND = 0;
  localparam int unsigned BIT_CSEL = 4;
  localparam int unsigned BIT_EN   = 5;
  localparam int unsigned BIT_TRIG = 6;

  typedef struct packed {
    trig_e trig;
    logic  en;
    logic  csel;
  } line_cfg_t;

  function automatic logic trig_is_edge(trig_e t);
    return t[1];
  endfunction
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic pin_i,
  output logic q_o,
  output logic pre_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     chain_q <= '0;
    else if (tick_i) chain_q <= {chain_q[STAGES-2:0], pin_i};
  end

  assign q_o   = chain_q[STAGES-1];
  assign pre_o = chain_q[STAGES-2];
endmodule

// File: rtl/eic_line.sv
module eic_line
  import eic_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic              slow_tick_i,
  input  logic              fast_tick_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wbyte_i,
  output logic [BYTE_W-1:0] rbyte_o,
  output logic              req_o,
  output logic              en_o,
  output logic [1:0]        trig_o,
  output logic              pend_o,
  output logic              tick_o,
  output logic              smp_o
);
  line_cfg_t cfg_q;
  logic      pend_q;
  logic      tick, smp, smp_pre, evt, active;
  trig_e     wtrig;

  assign tick  = cfg_q.csel ? fast_tick_i : slow_tick_i;
  assign wtrig = trig_e'(wbyte_i[BIT_TRIG+1:BIT_TRIG]);

  eic_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .pin_i (pin_i),
    .q_o   (smp),
    .pre_o (smp_pre)
  );

  // edge seen at the tick that moves the new value into the last stage
  always_comb begin
    unique case (cfg_q.trig)
      TRIG_RISE: evt = tick &  smp_pre & ~smp;
      TRIG_FALL: evt = tick & ~smp_pre &  smp;
      default:   evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '{trig: TRIG_HIGH, en: 1'b0, csel: 1'b0};
      pend_q <= 1'b0;
    end else begin
      if (wr_i && (wtrig != cfg_q.trig)) pend_q <= 1'b0;
      else if (evt)                      pend_q <= 1'b1;
      else if (wr_i && wbyte_i[BIT_PEND]) pend_q <= 1'b0;
      if (wr_i) begin
        cfg_q.trig <= wtrig;
        cfg_q.en   <= wbyte_i[BIT_EN];
        cfg_q.csel <= wbyte_i[BIT_CSEL];
      end
    end
  end

  always_comb begin
    unique case (cfg_q.trig)
      TRIG_HIGH: active = smp;
      TRIG_LOW:  active = ~smp;
      default:   active = pend_q;
    endcase
  end

  assign req_o   = cfg_q.en & active;
  assign rbyte_o = {cfg_q.trig, cfg_q.en, cfg_q.csel, 3'b000, active};
  assign en_o    = cfg_q.en;
  assign trig_o  = cfg_q.trig;
  assign pend_o  = pend_q;
  assign tick_o  = tick;
  assign smp_o   = smp;
endmodule

// File: rtl/eic_regmap.sv
module eic_regmap
  import eic_pkg::*;
#(
  parameter int unsigned N_LINES = 3,
  parameter int unsigned ADDR_W  = 2,
  parameter int unsigned DATA_W  = 32
) (
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic                           we_i,
  input  logic [DATA_W/BYTE_W-1:0]       be_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic                           shared_i,
  input  logic [N_LINES-1:0][BYTE_W-1:0] rbyte_i,
  output logic [N_LINES-1:0]             wr_o,
  output logic [N_LINES-1:0][BYTE_W-1:0] wbyte_o,
  output logic [DATA_W-1:0]              rdata_o
);
  for (genvar n = 0; n < N_LINES; n++) begin : g_dec
    localparam int unsigned LANE = N_LINES - 1 - n;
    logic sel_sep, sel_shr;
    assign sel_sep    = ~shared_i & (addr_i == ADDR_W'(n)) & be_i[0];
    assign sel_shr    =  shared_i & (addr_i == '0) & be_i[LANE];
    assign wr_o[n]    = we_i & (sel_sep | sel_shr);
    assign wbyte_o[n] = shared_i ? wdata_i[LANE*BYTE_W +: BYTE_W] : wdata_i[BYTE_W-1:0];
  end

  always_comb begin
    rdata_o = '0;
    for (int n = 0; n < N_LINES; n++) begin
      if (shared_i) begin
        if (addr_i == '0) rdata_o[(N_LINES-1-n)*BYTE_W +: BYTE_W] = rbyte_i[n];
      end else if (addr_i == ADDR_W'(n)) begin
        rdata_o[BYTE_W-1:0] = rbyte_i[n];
      end
    end
  end
endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
  import eic_pkg::*;
#(
  parameter int unsigned N_LINES     = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned PARENT_W    = 16,
  parameter int unsigned PARENT_BASE = 13
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_LINES-1:0]       pin_i,
  input  logic                     slow_tick_i,
  input  logic                     fast_tick_i,
  input  logic                     shared_mode_i,
  input  logic [ADDR_W-1:0]        reg_addr_i,
  input  logic                     reg_we_i,
  input  logic [DATA_W/BYTE_W-1:0] reg_be_i,
  input  logic [DATA_W-1:0]        reg_wdata_i,
  output logic [DATA_W-1:0]        reg_rdata_o,
  output logic [PARENT_W-1:0]      parent_req_o
);
  logic [N_LINES-1:0]             line_wr, line_req, line_en, line_pend, line_tick, line_smp;
  logic [N_LINES-1:0][BYTE_W-1:0] line_wbyte, line_rbyte;
  logic [N_LINES-1:0][1:0]        line_trig;

  eic_regmap #(.N_LINES(N_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regmap (
    .addr_i  (reg_addr_i),
    .we_i    (reg_we_i),
    .be_i    (reg_be_i),
    .wdata_i (reg_wdata_i),
    .shared_i(shared_mode_i),
    .rbyte_i (line_rbyte),
    .wr_o    (line_wr),
    .wbyte_o (line_wbyte),
    .rdata_o (reg_rdata_o)
  );

  for (genvar n = 0; n < N_LINES; n++) begin : g_line
    eic_line #(.SYNC_STAGES(SYNC_STAGES)) u_line (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_i      (pin_i[n]),
      .slow_tick_i(slow_tick_i),
      .fast_tick_i(fast_tick_i),
      .wr_i       (line_wr[n]),
      .wbyte_i    (line_wbyte[n]),
      .rbyte_o    (line_rbyte[n]),
      .req_o      (line_req[n]),
      .en_o       (line_en[n]),
      .trig_o     (line_trig[n]),
      .pend_o     (line_pend[n]),
      .tick_o     (line_tick[n]),
      .smp_o      (line_smp[n])
    );
  end

  always_comb begin
    parent_req_o = '0;
    parent_req_o[PARENT_BASE +: N_LINES] = line_req;
  end
endmodule

// File: rtl/eic_chk.sv
module eic_chk #(
  parameter int unsigned N_LINES     = 3,
  parameter int unsigned PARENT_W    = 16,
  parameter int unsigned PARENT_BASE = 13
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [PARENT_W-1:0]      parent_req_o,
  input logic [N_LINES-1:0]       line_wr,
  input logic [N_LINES-1:0][7:0]  line_wbyte,
  input logic [N_LINES-1:0][1:0]  line_trig,
  input logic [N_LINES-1:0]       line_en,
  input logic [N_LINES-1:0]       line_pend,
  input logic [N_LINES-1:0]       line_tick,
  input logic [N_LINES-1:0]       line_smp
);
  localparam logic [PARENT_W-1:0] USED = {{(PARENT_W-N_LINES){1'b0}}, {N_LINES{1'b1}}} << PARENT_BASE;

  a_r8_unused_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (parent_req_o & ~USED) == '0);

  for (genvar n = 0; n < N_LINES; n++) begin : g_a
    a_r6_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !line_en[n] |-> !parent_req_o[PARENT_BASE+n]);
    a_r10_type_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (line_wr[n] && (line_wbyte[n][7:6] != line_trig[n])) |=> !line_pend[n]);
    a_r4_pend_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (line_pend[n] && !line_wr[n]) |=> line_pend[n]);
    a_r5_level_no_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !line_trig[n][1] |-> !line_pend[n]);
    a_r7_no_tick_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !line_tick[n] |=> $stable(line_smp[n]));
  end
endmodule

bind ext_irq_cond eic_chk #(
  .N_LINES(N_LINES), .PARENT_W(PARENT_W), .PARENT_BASE(PARENT_BASE)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .parent_req_o(parent_req_o),
  .line_wr     (line_wr),
  .line_wbyte  (line_wbyte),
  .line_trig   (line_trig),
  .line_en     (line_en),
  .line_pend   (line_pend),
  .line_tick   (line_tick),
  .line_smp    (line_smp)
);

// File: tb/sim_ext_irq_cond.sv
module sim_ext_irq_cond;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  pin = '0;
  logic        slow_tick = 1'b0;
  logic        fast_tick = 1'b1;
  logic        shared = 1'b0;
  logic [1:0]  addr = '0;
  logic        we = 1'b0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] preq;
  int          n_chk = 0, n_err = 0, slow_cnt = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  ext_irq_cond u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pin), .slow_tick_i(slow_tick),
    .fast_tick_i(fast_tick), .shared_mode_i(shared), .reg_addr_i(addr),
    .reg_we_i(we), .reg_be_i(be), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .parent_req_o(preq)
  );

  always @(negedge clk) begin
    slow_cnt  <= (slow_cnt + 1) % 8;
    slow_tick <= (slow_cnt == 7);
  end

  // reference model
  logic [1:0] m_trig [3];
  bit m_en [3], m_csel [3], m_pend [3], m_s1 [3], m_s2 [3];

  function automatic bit m_active(int n);
    case (m_trig[n])
      2'b00:   return m_s2[n];
      2'b01:   return !m_s2[n];
      default: return m_pend[n];
    endcase
  endfunction

  function automatic logic [7:0] m_byte(int n);
    return {m_trig[n], m_en[n], m_csel[n], 3'b000, m_active(n)};
  endfunction

  function automatic logic [31:0] m_rdata();
    logic [31:0] r = '0;
    if (shared) begin
      if (addr == 0) r = {8'h00, m_byte(0), m_byte(1), m_byte(2)};
    end else if (addr < 3) r = {24'h0, m_byte(addr)};
    return r;
  endfunction

  function automatic logic [15:0] m_req();
    logic [15:0] r = '0;
    for (int n = 0; n < 3; n++) r[13+n] = m_en[n] & m_active(n);
    return r;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int n = 0; n < 3; n++) begin
        m_trig[n] = 2'b00; m_en[n] = 0; m_csel[n] = 0;
        m_pend[n] = 0; m_s1[n] = 0; m_s2[n] = 0;
      end
    end else begin
      for (int n = 0; n < 3; n++) begin
        bit tk, hit, ev;
        logic [7:0] b;
        tk = m_csel[n] ? fast_tick : slow_tick;
        if (shared) begin
          hit = we && addr == 0 && be[2-n];
          b   = wdata[(2-n)*8 +: 8];
        end else begin
          hit = we && addr == n && be[0];
          b   = wdata[7:0];
        end
        ev = tk && ((m_trig[n] == 2'b10 && m_s1[n] && !m_s2[n]) ||
                    (m_trig[n] == 2'b11 && !m_s1[n] && m_s2[n]));
        if (hit && b[7:6] != m_trig[n]) m_pend[n] = 0;
        else if (ev)                    m_pend[n] = 1;
        else if (hit && b[0])           m_pend[n] = 0;
        if (tk) begin m_s2[n] = m_s1[n]; m_s1[n] = pin[n]; end
        if (hit) begin m_trig[n] = b[7:6]; m_en[n] = b[5]; m_csel[n] = b[4]; end
      end
    end
  end

  // cycle compare against the model
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      n_chk += 2;
      if (preq !== m_req()) begin
        n_err++;
        $display("FAIL R3 model request act=%h exp=%h t=%0t", preq, m_req(), $time);
      end
      if (rdata !== m_rdata()) begin
        n_err++;
        $display("FAIL R2 model readback act=%h exp=%h t=%0t", rdata, m_rdata(), $time);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(int k);
    repeat (k) @(negedge clk);
    #1;
  endtask

  task automatic wr(logic [1:0] a, logic [3:0] e, logic [31:0] d);
    addr = a; be = e; wdata = d; we = 1'b1;
    cyc(1);
    we = 1'b0; be = '0;
  endtask

  task automatic rd(logic [1:0] a, logic [31:0] exp, string tag);
    addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    cyc(2);
    rst_ni = 1'b1;
    cyc(1);
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    // R1 reset state, R11 per-address layout
    rd(0, 32'h0, "R1 line0 reset"); rd(1, 32'h0, "R1 line1 reset");
    rd(2, 32'h0, "R1 line2 reset"); rd(3, 32'h0, "R11 addr3 reset");
    chk("R1 parent reset", preq, 16'h0);

    // line0 high level, fast, enabled
    wr(0, 4'h1, 32'h30);
    pin[0] = 1'b1;
    cyc(1); chk("R7 one fast tick not enough", preq, 16'h0);
    cyc(1); chk("R8 line0 to parent bit13", preq, 16'h2000);
    rd(0, 32'h31, "R5 level pending reads active");
    wr(0, 4'h1, 32'h31);
    rd(0, 32'h31, "R5 w1c ignored in level mode");
    chk("R5 request kept after w1c", preq, 16'h2000);
    pin[0] = 1'b0; cyc(3);
    rd(0, 32'h30, "R3 high level released");

    // line1 low level
    wr(1, 4'h1, 32'h70);
    chk("R3 low level active on low pin", preq, 16'h4000);
    rd(1, 32'h71, "R3 low level readback");
    pin[1] = 1'b1; cyc(3);
    chk("R3 low level idle on high pin", preq, 16'h0);

    // line2 rising edge latch and clear
    wr(2, 4'h1, 32'hB0);
    pin[2] = 1'b1; cyc(3);
    chk("R4 rising edge request", preq, 16'h8000);
    pin[2] = 1'b0; cyc(3);
    rd(2, 32'hB1, "R4 pending held after pin drops");
    wr(2, 4'h1, 32'hB1);
    rd(2, 32'hB0, "R4 w1c clears pending");
    chk("R4 request gone after clear", preq, 16'h0);

    // masking
    wr(2, 4'h1, 32'h90);
    pin[2] = 1'b1; cyc(3);
    rd(2, 32'h91, "R6 masked line still latches");
    chk("R6 masked request low", preq, 16'h0);
    wr(2, 4'h1, 32'hB0);
    chk("R6 unmask releases request", preq, 16'h8000);

    // type change clears pending, then falling edge
    wr(2, 4'h1, 32'hF0);
    rd(2, 32'hF0, "R10 type change clears pending");
    pin[2] = 1'b0; cyc(3);
    rd(2, 32'hF1, "R3 falling edge latched");
    chk("R3 falling edge request", preq, 16'h8000);
    wr(2, 4'h1, 32'hF1);

    // slow sample rate on line0
    wr(0, 4'h1, 32'h20);
    pin[0] = 1'b1;
    cyc(1); chk("R7 slow rate not yet sampled", preq, 16'h0);
    cyc(20); chk("R7 slow rate sampled", preq, 16'h2000);
    pin[0] = 1'b0; cyc(20);

    // unused address
    wr(3, 4'hF, 32'hFFFF_FFFF);
    rd(3, 32'h0, "R11 addr3 reads zero");
    rd(0, 32'h20, "R11 line0 untouched"); rd(1, 32'h70, "R11 line1 untouched");
    rd(2, 32'hF0, "R11 line2 untouched");

    // edge coincident with clear
    wr(2, 4'h1, 32'hB0);
    pin[2] = 1'b1;
    cyc(1);
    addr = 2; be = 4'h1; wdata = 32'hB1; we = 1'b1;
    @(negedge clk);
    chk("R12 edge beats clear", rdata, 32'hB1);
    #1; we = 1'b0; be = '0;
    wr(2, 4'h1, 32'hB1);
    rd(2, 32'hB0, "R4 cleared after coincidence");

    // shared layout
    pin = 3'b000; shared = 1'b1;
    do_reset();
    rd(0, 32'h0, "R1 shared reset");
    wr(0, 4'b0100, 32'h0030_0000);
    rd(0, 32'h0030_0000, "R9 line0 in bits 23:16");
    wr(0, 4'b0001, 32'h0000_0070);
    rd(0, 32'h0030_0071, "R9 line2 in bits 7:0");
    chk("R9 line2 request", preq, 16'h8000);
    wr(0, 4'b0010, 32'hFFFF_FFFF);
    rd(0, 32'h0030_F071, "R9 only line1 byte written, R2 reserved bits zero");
    rd(1, 32'h0, "R9 other address reads zero");
    cyc(2);
    finish_run();
  end
endmodule